// File: doc/BRIEF.md
# Power-Mode Conversion Scheduler

This block decides when a multi-stage capacitance conversion sequence runs. While the sensors are in use it runs in full-power mode: each sequence walks the stage index from 0 up to a programmed last stage, advancing once per stage-done report from the converter, and the next sequence starts as soon as one ends. Millisecond ticks are counted while nothing is touched. Once the count reaches a programmable power-down timeout, the scheduler finishes the current sequence and drops into low-power mode.

In low-power mode the scheduler stays idle for a wake interval. A 2-bit code selects an interval of one to four wake steps, and a step is 200 ms by default. After the interval it runs exactly one sequence and then goes idle again. Any touch or proximity indication returns it to full-power mode at once. The converter and the calibration logic sit outside this block. They see only a one-cycle sequence-start pulse and the current stage index.

Top module: `pwr_conv_sched`

## Requirements
- R1: While synchronous reset is held, `lp_mode` is 0, `stage_idx` is 0 and `seq_start` is 0. In the first cycle after reset is released, `seq_start` pulses for one cycle with `stage_idx` at 0, in full-power mode.
- R2: While a sequence runs, `stage_idx` rises by exactly one in the cycle after each `stage_done`. In cycles with no `stage_done` it holds its value.
- R3: In full-power mode, a `stage_done` at stage `last_stage` is followed in the next cycle by a `seq_start` pulse with `stage_idx` at 0, so sequences run back to back.
- R4: The scheduler enters low-power mode (`lp_mode`=1, no `seq_start`, `stage_idx`=0) at the end of a full-power sequence only under two conditions: at least `pd_timeout` ms ticks have arrived since the last touch, and `touch` is low. When `pd_timeout` is 0, the first sequence that ends without a touch drops the scheduler to low power.
- R5: In low-power idle, the scheduler wakes on the ms tick that brings the idle tick count to (`lp_delay_code`+1)·STEP_MS. For example, code 0 gives 200 ms and code 3 gives 800 ms. On waking it pulses `seq_start`, runs one sequence and returns to idle with `stage_idx` at 0. Cycles without a tick do not count toward the interval.
- R6: A `touch` in low-power mode clears `lp_mode` in the next cycle. From idle it also starts a fresh sequence (`seq_start`=1, stage 0). In the middle of a low-power sequence it keeps the current stage. Either way the timeout count restarts from zero.
- R7: A `touch` in full-power mode restarts the timeout count from zero.
- R8: A `stage_done` during low-power idle has no effect: `stage_idx` stays 0 and no sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| touch | input | 1 | Touch or proximity activity seen on any sensor |
| stage_done | input | 1 | Converter finished the current stage |
| last_stage | input | STG_W | Index of the final stage in a sequence |
| lp_delay_code | input | 2 | Low-power wake interval code (interval = code+1 steps) |
| pd_timeout | input | IDLE_W | Untouched ms ticks needed before dropping to low power |
| seq_start | output | 1 | One-cycle pulse when a sequence begins at stage 0 |
| stage_idx | output | STG_W | Stage currently being converted |
| lp_mode | output | 1 | 1 while in low-power mode (idle or running its single sequence) |

## Verification
The assertions take several things about the inputs for granted. `stage_done` arrives only as the converter's report for the stage shown. `last_stage`, `pd_timeout` and `lp_delay_code` stay stable across any sequence or wake interval they govern. `ms_tick` lasts one cycle. The stimulus respects these assumptions. It changes configuration only at reset or while the scheduler is idle in low power or at stage 0 of a fresh sequence. It drives every input from the cycle just after a clock edge. It runs with a small wake step, so that every delay code and several timeouts can be covered in full.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [1:0] {
      PM_FULL    = 2'd0,
      PM_LP_IDLE = 2'd1,
      PM_LP_RUN  = 2'd2
   } pm_state_t;

   function automatic logic pm_is_running(input pm_state_t s);
      return (s == PM_FULL) || (s == PM_LP_RUN);
   endfunction

endpackage

// File: rtl/pcs_interval.sv
module pcs_interval #(
   parameter int STEP_MS   = 200,
   parameter int WAKE_W    = 10,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [1:0]        code,
   output logic [WAKE_W-1:0] interval
);
   localparam int MAX_IV = 4 * STEP_MS;

   generate
      if (STEP_MS < 1) begin : g_bad_step
         $error("pcs_interval: STEP_MS must be at least 1");
      end
      if ((1 << WAKE_W) <= MAX_IV) begin : g_bad_width
         $error("pcs_interval: WAKE_W too narrow for longest interval");
      end

      if (USE_TABLE) begin : g_table
         always_comb begin
            unique case (code)
               2'd0:    interval = WAKE_W'(STEP_MS);
               2'd1:    interval = WAKE_W'(2 * STEP_MS);
               2'd2:    interval = WAKE_W'(3 * STEP_MS);
               default: interval = WAKE_W'(4 * STEP_MS);
            endcase
         end
      end else begin : g_mult
         logic [WAKE_W-1:0] steps;
         assign steps    = WAKE_W'({1'b0, code}) + WAKE_W'(1);
         assign interval = WAKE_W'(steps * WAKE_W'(STEP_MS));
      end
   endgenerate

endmodule

// File: rtl/pcs_ms_counter.sv
module pcs_ms_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAXV = '1;

   generate
      if (W < 1) begin : g_bad_w
         $error("pcs_ms_counter: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr)
         count <= '0;
      else if (inc && count != MAXV)
         count <= count + W'(1);
   end

endmodule

// File: rtl/pcs_stage_ctr.sv
module pcs_stage_ctr #(
   parameter int STG_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             adv,
   output logic [STG_W-1:0] idx
);
   always_ff @(posedge clk) begin
      if (rst || clr)
         idx <= '0;
      else if (adv)
         idx <= idx + STG_W'(1);
   end

endmodule

// File: rtl/pwr_conv_sched.sv
module pwr_conv_sched
   import pcs_pkg::*;
#(
   parameter int STG_W     = 3,
   parameter int IDLE_W    = 12,
   parameter int STEP_MS   = 200,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ms_tick,
   input  logic              touch,
   input  logic              stage_done,
   input  logic [STG_W-1:0]  last_stage,
   input  logic [1:0]        lp_delay_code,
   input  logic [IDLE_W-1:0] pd_timeout,
   output logic              seq_start,
   output logic [STG_W-1:0]  stage_idx,
   output logic              lp_mode
);
   localparam int WAKE_W = $clog2(4 * STEP_MS + 1);

   generate
      if (STG_W < 1 || IDLE_W < 1) begin : g_bad_cfg
         $error("pwr_conv_sched: widths must be positive");
      end
   endgenerate

   pm_state_t         state_q, state_d;
   logic              boot_q;
   logic              start_d;
   logic              stage_clr;
   logic              running;
   logic              end_seq;
   logic              idle_expired;
   logic              wake;
   logic [IDLE_W-1:0] idle_cnt;
   logic [WAKE_W-1:0] wake_cnt;
   logic [WAKE_W-1:0] wake_iv;

   assign running      = pm_is_running(state_q);
   assign end_seq      = running && stage_done && (stage_idx == last_stage);
   assign idle_expired = (idle_cnt >= pd_timeout);
   assign wake         = (state_q == PM_LP_IDLE) && ms_tick &&
                         (wake_cnt == wake_iv - WAKE_W'(1));

   pcs_interval #(
      .STEP_MS  (STEP_MS),
      .WAKE_W   (WAKE_W),
      .USE_TABLE(USE_TABLE)
   ) u_interval (
      .code    (lp_delay_code),
      .interval(wake_iv)
   );

   pcs_ms_counter #(.W(IDLE_W)) u_idle_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (touch || (state_q != PM_FULL)),
      .inc  (ms_tick && (state_q == PM_FULL)),
      .count(idle_cnt)
   );

   pcs_ms_counter #(.W(WAKE_W)) u_wake_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (state_q != PM_LP_IDLE),
      .inc  (ms_tick),
      .count(wake_cnt)
   );

   always_comb begin
      state_d   = state_q;
      start_d   = 1'b0;
      stage_clr = 1'b0;
      unique case (state_q)
         PM_FULL: begin
            if (boot_q) begin
               start_d = 1'b1;
            end else if (end_seq) begin
               stage_clr = 1'b1;
               if (idle_expired && !touch)
                  state_d = PM_LP_IDLE;
               else
                  start_d = 1'b1;
            end
         end
         PM_LP_RUN: begin
            if (touch) begin
               state_d = PM_FULL;
               if (end_seq) begin
                  stage_clr = 1'b1;
                  start_d   = 1'b1;
               end
            end else if (end_seq) begin
               state_d   = PM_LP_IDLE;
               stage_clr = 1'b1;
            end
         end
         PM_LP_IDLE: begin
            if (touch) begin
               state_d = PM_FULL;
               start_d = 1'b1;
            end else if (wake) begin
               state_d = PM_LP_RUN;
               start_d = 1'b1;
            end
         end
         default: state_d = PM_FULL;
      endcase
      if (start_d) stage_clr = 1'b1;
   end

   pcs_stage_ctr #(.STG_W(STG_W)) u_stage (
      .clk(clk),
      .rst(rst),
      .clr(stage_clr),
      .adv(running && stage_done),
      .idx(stage_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= PM_FULL;
         boot_q    <= 1'b1;
         seq_start <= 1'b0;
      end else begin
         state_q   <= state_d;
         boot_q    <= 1'b0;
         seq_start <= start_d;
      end
   end

   assign lp_mode = (state_q != PM_FULL);

   assert_stage_moves_on_done_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(stage_idx) |-> $past(stage_done));

   assert_start_at_stage0_R3: assert property (@(posedge clk) disable iff (rst)
      seq_start |-> (stage_idx == '0));

   assert_drop_needs_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(lp_mode) |-> !$past(touch));

   assert_idle_no_spurious_start_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == PM_LP_IDLE && !ms_tick && !touch) |=> !seq_start);

   assert_touch_exits_lp_R6: assert property (@(posedge clk) disable iff (rst)
      (lp_mode && touch) |=> !lp_mode);

   assert_idle_ignores_done_R8: assert property (@(posedge clk) disable iff (rst)
      (state_q == PM_LP_IDLE) |-> (stage_idx == '0));

endmodule

// File: tb/pwr_conv_sched_tb.sv
module pwr_conv_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int STG_W      = 3;
   localparam int IDLE_W     = 12;
   localparam int STEP       = 3;
   localparam int LAST       = 2;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              ms_tick = 1'b0;
   logic              touch = 1'b0;
   logic              stage_done = 1'b0;
   logic [STG_W-1:0]  last_stage = STG_W'(LAST);
   logic [1:0]        lp_delay_code = 2'd0;
   logic [IDLE_W-1:0] pd_timeout = '0;
   logic              seq_start;
   logic [STG_W-1:0]  stage_idx;
   logic              lp_mode;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_conv_sched #(
      .STG_W  (STG_W),
      .IDLE_W (IDLE_W),
      .STEP_MS(STEP)
   ) u_dut (
      .clk          (clk),
      .rst          (rst),
      .ms_tick      (ms_tick),
      .touch        (touch),
      .stage_done   (stage_done),
      .last_stage   (last_stage),
      .lp_delay_code(lp_delay_code),
      .pd_timeout   (pd_timeout),
      .seq_start    (seq_start),
      .stage_idx    (stage_idx),
      .lp_mode      (lp_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic outs(input string req, input int lp, input int st, input int stg);
      chk({req, " lp_mode"}, int'(lp_mode), lp);
      chk({req, " seq_start"}, int'(seq_start), st);
      chk({req, " stage_idx"}, int'(stage_idx), stg);
   endtask

   // inputs change just after an edge; outputs read one step after the next edge
   task automatic cyc(input logic t, input logic d, input logic k);
      touch = t; stage_done = d; ms_tick = k;
      @(posedge clk); #1;
      touch = 1'b0; stage_done = 1'b0; ms_tick = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) cyc(0, 0, 0);
      outs("R1 in reset", 0, 0, 0);
      rst = 1'b0;
      cyc(0, 0, 0);
      outs("R1 boot start", 0, 1, 0);
   endtask

   // run stages 0..LAST from stage 0; check the final response
   task automatic run_seq(input string req, input int lp, input int st);
      for (int k = 0; k < LAST; k++) begin
         cyc(0, 1, 0);
         chk({req, " R2 advance"}, int'(stage_idx), k + 1);
      end
      cyc(0, 1, 0);
      outs(req, lp, st, 0);
   endtask

   initial begin
      @(posedge clk); #1;
      pd_timeout = IDLE_W'(100);
      do_reset();
      cyc(0, 0, 0);
      outs("R1 pulse one cycle", 0, 0, 0);

      // R2/R3 sweep over sequence lengths with idle gaps between done pulses
      for (int L = 0; L < 4; L++) begin
         last_stage = STG_W'(L);
         do_reset();
         for (int k = 0; k <= L; k++) begin
            cyc(1, 0, 0);
            chk("R2 hold without done", int'(stage_idx), k);
            cyc(1, 1, 0);
            if (k < L) outs("R2 step", 0, 0, k + 1);
            else       outs("R3 back to back", 0, 1, 0);
         end
      end
      last_stage = STG_W'(LAST);

      // R4 timeout sweep
      for (int T = 0; T < 6; T += 2) begin
         pd_timeout = IDLE_W'(T);
         do_reset();
         if (T > 0) begin
            repeat (T - 1) cyc(0, 0, 1);
            run_seq("R4 short of timeout", 0, 1);
            cyc(0, 0, 1);
         end
         run_seq("R4 drop to low power", 1, 0);
      end

      // R5 every wake code, with R8 done pulses ignored while idle
      for (int c = 0; c < 4; c++) begin
         lp_delay_code = 2'(c);
         for (int i = 0; i < (c + 1) * STEP - 1; i++) begin
            cyc(0, 1, 0);
            cyc(0, 0, 1);
         end
         outs("R8 idle ignores done", 1, 0, 0);
         cyc(0, 0, 1);
         outs("R5 wake start", 1, 1, 0);
         run_seq("R5 single sequence then idle", 1, 0);
      end

      // R6 touch while idle
      cyc(1, 0, 0);
      outs("R6 touch from idle", 0, 1, 0);
      pd_timeout = IDLE_W'(2);
      cyc(0, 0, 1);
      run_seq("R6 count restarted", 0, 1);
      cyc(0, 0, 1);
      run_seq("R6 timeout reached", 1, 0);

      // R6 touch during a low-power sequence
      lp_delay_code = 2'd0;
      repeat (STEP) cyc(0, 0, 1);
      outs("R5 wake code0", 1, 1, 0);
      cyc(0, 1, 0);
      cyc(1, 0, 0);
      outs("R6 touch mid sequence", 0, 0, 1);
      cyc(0, 1, 0);
      cyc(0, 1, 0);
      outs("R3 full restart after touch", 0, 1, 0);

      // R7 touch in full power restarts the count
      pd_timeout = IDLE_W'(3);
      cyc(0, 0, 1);
      cyc(0, 0, 1);
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      cyc(0, 0, 1);
      run_seq("R7 touch cleared count", 0, 1);
      cyc(0, 0, 1);
      run_seq("R7 count reaches timeout", 1, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule